// File: doc/BRIEF.md
# Three-read one-write register file

This block is the general-purpose register array of a small pipelined 32-bit processor. Three read ports serve operand A, operand B and the destination or store-data operand D in the same cycle. One write port takes results from the writeback stage. The array is made of three mirrored single-write memories. Each write lands in all three copies, and each copy feeds exactly one read port, so no port ever waits for another.

Reads are synchronous. The decode logic presents read addresses ahead of the clock edge, using its next-state values, and the data is registered at that edge. The data therefore arrives together with the decoded instruction one cycle later. When a read and a write hit the same register in the same enabled cycle, the read returns the value being written. A single clock enable freezes the whole array, covering writes and the read data registers alike. Register 0 always reads as zero.

Top module: `trio_regfile`

## Requirements
- R1: Read data for an address presented before an enabled rising edge appears on that port's data output after that edge and not before.
- R2: The three read ports are independent. In one cycle each port returns the contents of its own address.
- R3: A write with write enable high and clock enable high updates all three copies, so the new value is readable on ports A, B and D alike.
- R4: If an enabled write targets a nonzero address that a port reads in the same cycle, that port returns the newly written data.
- R5: A read of address 0 returns zero, even in a cycle that tries to write address 0 and after such a write.
- R6: While clock enable is low, all read data outputs hold their values and a write request leaves the contents unchanged.
- R7: When write enable is low, an enabled cycle leaves the contents unchanged.
- R8: Synchronous active-high reset clears the three read data outputs to zero. It does not clear the stored contents.
- R9: After a stall, the first enabled edge loads the read data for the addresses presented in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset of the read data registers, active high |
| clkEn | input | 1 | Global enable for reads and writes |
| rdAddrA | input | 5 | Operand A read address |
| rdAddrB | input | 5 | Operand B read address |
| rdAddrD | input | 5 | Operand D read address |
| wrEn | input | 1 | Write request from writeback |
| wrAddr | input | 5 | Write address |
| wrData | input | 32 | Write data |
| rdDataA | output | 32 | Operand A read data |
| rdDataB | output | 32 | Operand B read data |
| rdDataD | output | 32 | Operand D read data |

## Verification
The hardest situation to reach is a write request that arrives during a stall. Its effect stays hidden until a later enabled read of the same register. The stimulus therefore issues stalled writes to registers whose values are already known, with the addresses changing during the stall. It then reads those registers on all three ports at the first enabled edge. Collisions are produced by filling the array while two ports read the register being written. The stream also includes a reset in the middle of the run, followed by reads that show the contents survived it.

// File: rtl/trio_rf_pkg.sv
package trio_rf_pkg;
  typedef struct packed {
    logic wrStrobe;
    logic capStrobe;
  } rfStrobes_t;
endpackage

// File: rtl/trio_rf_ctrl.sv
module trio_rf_ctrl
  import trio_rf_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clkEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  output rfStrobes_t        strobes
);
  // Register 0 is hard zero: a write there is dropped here.
  logic wrAddrLive;
  assign wrAddrLive        = |wrAddr;
  assign strobes.wrStrobe  = clkEn & wrEn & wrAddrLive;
  assign strobes.capStrobe = clkEn;
endmodule

// File: rtl/trio_rf_bank.sv
module trio_rf_bank
  import trio_rf_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int NUM_RD = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  rfStrobes_t        strobes,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr [NUM_RD],
  output logic [DATA_W-1:0] rdData [NUM_RD]
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar p = 0; p < NUM_RD; p++) begin : g_copy
    logic [DATA_W-1:0] mem [DEPTH];
    logic              hitZero;
    logic              hitWrite;
    logic [DATA_W-1:0] readNext;

    always_ff @(posedge clk) begin
      if (strobes.wrStrobe) mem[wrAddr] <= wrData;
    end

    assign hitZero  = (rdAddr[p] == '0);
    assign hitWrite = strobes.wrStrobe && (rdAddr[p] == wrAddr);

    always_comb begin
      if (hitZero)       readNext = '0;
      else if (hitWrite) readNext = wrData;
      else               readNext = mem[rdAddr[p]];
    end

    always_ff @(posedge clk) begin
      if (rst)                    rdData[p] <= '0;
      else if (strobes.capStrobe) rdData[p] <= readNext;
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
      rst |=> rdData[p] == '0); // R8
    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
      !strobes.capStrobe |=> $stable(rdData[p])); // R6
    AST_ZERO_READ: assert property (@(posedge clk) disable iff (rst)
      strobes.capStrobe && rdAddr[p] == '0 |=> rdData[p] == '0); // R5
    AST_WRITE_BYPASS: assert property (@(posedge clk) disable iff (rst)
      strobes.wrStrobe && rdAddr[p] == wrAddr |=> rdData[p] == $past(wrData)); // R4
    if (p > 0) begin : g_mirror
      AST_COPIES_AGREE: assert property (@(posedge clk) disable iff (rst)
        strobes.capStrobe && rdAddr[p] == rdAddr[0] |=> rdData[p] == rdData[0]); // R3
    end
  end
endmodule

// File: rtl/trio_regfile.sv
module trio_regfile
  import trio_rf_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clkEn,
  input  logic [ADDR_W-1:0] rdAddrA,
  input  logic [ADDR_W-1:0] rdAddrB,
  input  logic [ADDR_W-1:0] rdAddrD,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdDataA,
  output logic [DATA_W-1:0] rdDataB,
  output logic [DATA_W-1:0] rdDataD
);
  localparam int NUM_RD = 3;

  rfStrobes_t        strobes;
  logic [ADDR_W-1:0] rdAddr [NUM_RD];
  logic [DATA_W-1:0] rdData [NUM_RD];

  assign rdAddr[0] = rdAddrA;
  assign rdAddr[1] = rdAddrB;
  assign rdAddr[2] = rdAddrD;
  assign rdDataA   = rdData[0];
  assign rdDataB   = rdData[1];
  assign rdDataD   = rdData[2];

  trio_rf_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clkEn   (clkEn),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .strobes (strobes)
  );

  trio_rf_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_RD(NUM_RD)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .wrAddr  (wrAddr),
    .wrData  (wrData),
    .rdAddr  (rdAddr),
    .rdData  (rdData)
  );
endmodule

// File: tb/trio_regfile_bench.sv
module trio_regfile_bench;
  typedef struct {
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] d;
    string       req;
  } expItem_t;

  logic        clk = 0;
  logic        rst = 1;
  logic        clkEn = 0;
  logic [4:0]  rdAddrA = 0, rdAddrB = 0, rdAddrD = 0, wrAddr = 0;
  logic        wrEn = 0;
  logic [31:0] wrData = 0;
  logic [31:0] rdDataA, rdDataB, rdDataD;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  expItem_t expQ[$];
  logic [31:0] model [32];
  logic [31:0] lastA = 0, lastB = 0, lastD = 0;

  always #5 clk = ~clk;

  trio_regfile u_trio_regfile (
    .clk(clk), .rst(rst), .clkEn(clkEn),
    .rdAddrA(rdAddrA), .rdAddrB(rdAddrB), .rdAddrD(rdAddrD),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdDataA(rdDataA), .rdDataB(rdDataB), .rdDataD(rdDataD)
  );

  function automatic logic [31:0] pat(input int i, input int salt);
    return 32'h5A3C_0000 ^ (i * 32'h0101_0203) ^ (salt * 32'h1000_0001);
  endfunction

  function automatic logic [31:0] modelRead(input logic [4:0] ad, input logic en,
                                            input logic we, input logic [4:0] wa,
                                            input logic [31:0] wd);
    if (ad == 0) return 32'h0;
    if (en && we && wa == ad) return wd;
    return model[ad];
  endfunction

  task automatic cmp(input string req, input string port, input logic [31:0] got,
                     input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s port %s: got %h expected %h", req, port, got, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus and pushes the expected outputs.
  task automatic step(input logic en, input logic we, input logic [4:0] wa,
                      input logic [31:0] wd, input logic [4:0] aa,
                      input logic [4:0] ab, input logic [4:0] ad, input string req);
    expItem_t it;
    @(negedge clk);
    rst = 0; clkEn = en; wrEn = we; wrAddr = wa; wrData = wd;
    rdAddrA = aa; rdAddrB = ab; rdAddrD = ad;
    if (en) begin
      lastA = modelRead(aa, en, we, wa, wd);
      lastB = modelRead(ab, en, we, wa, wd);
      lastD = modelRead(ad, en, we, wa, wd);
      if (we && wa != 0) model[wa] = wd;
    end
    it.a = lastA; it.b = lastB; it.d = lastD; it.req = req;
    expQ.push_back(it);
  endtask

  task automatic pulseReset();
    expItem_t it;
    @(negedge clk);
    rst = 1; clkEn = 1; wrEn = 0;
    lastA = 0; lastB = 0; lastD = 0;
    it.a = 0; it.b = 0; it.d = 0; it.req = "R8";
    expQ.push_back(it);
  endtask

  // Monitor: compares after each rising edge.
  always @(posedge clk) begin
    #1;
    if (expQ.size() > 0) begin
      expItem_t it;
      it = expQ.pop_front();
      cmp(it.req, "A", rdDataA, it.a);
      cmp(it.req, "B", rdDataB, it.b);
      cmp(it.req, "D", rdDataD, it.d);
    end
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    cmp("R8", "A", rdDataA, 0);
    cmp("R8", "B", rdDataB, 0);
    cmp("R8", "D", rdDataD, 0);

    // Fill the array; A and D read the register being written (R4), B reads 0 (R5).
    for (int i = 1; i < 32; i++) step(1, 1, 5'(i), pat(i, 0), 5'(i), 0, 5'(i), "R4");

    // Independent reads with one-cycle latency (R1, R2).
    for (int i = 1; i < 30; i++) step(1, 0, 0, 0, 5'(i), 5'(i + 1), 5'(i + 2), "R2");
    step(1, 0, 0, 0, 5'd31, 5'd3, 5'd17, "R1");

    // Write attempt to register 0 (R5).
    step(1, 1, 0, 32'hFFFF_FFFF, 0, 0, 0, "R5");
    step(1, 0, 0, 0, 0, 5'd4, 0, "R5");

    // Stalled write is dropped and outputs hold (R6).
    step(0, 1, 5'd7, 32'hDEAD_BEEF, 5'd1, 5'd2, 5'd3, "R6");
    step(0, 1, 5'd8, 32'hCAFE_F00D, 5'd9, 5'd10, 5'd11, "R6");
    // First enabled edge after the stall (R9).
    step(1, 0, 0, 0, 5'd7, 5'd8, 5'd7, "R9");

    // Write enable low leaves contents (R7).
    step(1, 0, 5'd12, 32'h1234_5678, 5'd1, 5'd1, 5'd1, "R7");
    step(1, 0, 0, 0, 5'd12, 5'd12, 5'd12, "R7");

    // Write reaches all three copies (R3).
    step(1, 1, 5'd20, 32'h0BAD_C0DE, 5'd1, 5'd2, 5'd3, "R3");
    step(1, 0, 0, 0, 5'd20, 5'd20, 5'd20, "R3");

    // Collision on all ports at once (R4).
    step(1, 1, 5'd21, 32'h7777_1111, 5'd21, 5'd21, 5'd21, "R4");

    // Mid-run reset clears outputs only (R8).
    pulseReset();
    step(0, 0, 0, 0, 5'd5, 5'd6, 5'd7, "R8");
    step(1, 0, 0, 0, 5'd5, 5'd21, 5'd31, "R8");

    // Back-to-back writes and reads with stalls between (R9).
    for (int i = 1; i < 6; i++) begin
      step(1, 1, 5'(i + 24), pat(i, 3), 5'(i), 5'(i + 24), 5'(i + 23), "R4");
      step(0, 0, 0, 0, 5'(i + 10), 5'(i + 11), 5'(i + 12), "R6");
      step(1, 0, 0, 0, 5'(i + 24), 5'(i + 23), 5'(i + 22), "R9");
    end

    while (expQ.size() > 0) @(negedge clk);
    @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule